// File: doc/BRIEF.md
# ISA Byte-Wide Register Interface

This block is the host-side register file of a small position-output card that sits in the 8-bit I/O space of an ISA-style bus. Five switch inputs set the upper address bits, and the card answers inside one 32-byte window aligned to that base. Each 16-bit quantity is split into a low byte at an even offset and a high byte at the next odd offset.

There are four command words, which the host writes and the core receives: position, excitation frequency, excitation amplitude and transformation ratio. There are also four sources that the core drives and the host reads: the wrap-around position and three status bytes. Four identity words are fixed at build time.

The bus strobes arrive already synchronised to the block clock as one-cycle pulses. A byte read appears on the registered data output one cycle after its strobe.

Two byte orderings keep multi-byte values coherent. A command word reaches the core only when its high byte is written. Reading the high byte of the wrap-around word freezes the matching low byte until that low byte is read.

Top module: `isa_rif`

## Requirements
- R1: An access is taken only when addr[9:5] equals base_sw. A read outside the window leaves rdata unchanged and does not capture the wrap-around low byte. A write outside the window changes no register.
- R2: After reset, pos_o = 0, exc_o = 0 (excitation off), ratio_o = 0, freq_o = 360 (0x0168), and rdata = 0x00.
- R3: The command words sit at these offsets (low byte at the even offset, high byte at the odd one): position 0x00/0x01, frequency 0x06/0x07, excitation amplitude 0x08/0x09, ratio 0x0A/0x0B. On the clock edge that takes a high-byte write strobe, the core output becomes {written byte, last low byte written}. Every 16-bit pattern passes through unchanged, including two's-complement positions such as 0x8000. Amplitude is in steps of 0.1 Vrms (281 means 28.1 Vrms) and frequency is in Hz.
- R4: A write to the low-byte offset alone leaves the core output word unchanged.
- R5: Reading a command-word offset returns the matching byte of the word currently applied to the core: bits 7:0 at the even offset and bits 15:8 at the odd one.
- R6: A read of offset 0x03 returns wrap_i[15:8] and captures wrap_i[7:0] in the same cycle. The next read of 0x02 returns the captured byte, whatever wrap_i has become, and releases the capture.
- R7: A read of 0x02 with no capture pending returns the live wrap_i[7:0].
- R8: Offset 0x04 reads acc_stat_i, 0x16 reads sig_stat_i and 0x18 reads exc_stat_i.
- R9: The identity words read as parameters at these offsets: model 0x0C/0x0D, serial 0x10/0x11, date 0x12/0x13, revision 0x14/0x15. Writes to these offsets are ignored.
- R10: Offsets 0x05, 0x0E, 0x0F, 0x17 and 0x19 through 0x1F read 0x00. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sw | input | 5 | Base-address switch value, compared with addr[9:5] |
| addr | input | 10 | I/O byte address |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| pos_o | output | 16 | Position command to core |
| freq_o | output | 16 | Excitation frequency command, Hz |
| exc_o | output | 16 | Excitation amplitude command, 0.1 Vrms steps |
| ratio_o | output | 16 | Transformation ratio command |
| wrap_i | input | 16 | Measured wrap-around position from core |
| acc_stat_i | input | 8 | Accuracy test status byte |
| sig_stat_i | input | 8 | Signal status byte |
| exc_stat_i | input | 8 | Excitation status byte |

## Verification
The wrap-around capture and the core's update of wrap_i can land on the same clock edge. The bench provokes this by changing wrap_i in the same cycle as the high-byte read strobe, then changing it again before the low-byte read. The check requires both returned bytes to come from the single sample taken at the capture edge and not from the later value. A second pairing puts a low-byte write directly before the high-byte commit: the core word must stay unchanged across the low write and then take both bytes together.

// File: rtl/isa_rif_pkg.sv
package isa_rif_pkg;
  localparam int WIN_W    = 5;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int NWREG    = 4;

  localparam logic [WIN_W-1:0] OFF_WRAP_LO = 5'h02;
  localparam logic [WIN_W-1:0] OFF_WRAP_HI = 5'h03;
  localparam logic [WIN_W-1:0] OFF_ACC     = 5'h04;
  localparam logic [WIN_W-1:0] OFF_MODEL   = 5'h0C;
  localparam logic [WIN_W-1:0] OFF_SERIAL  = 5'h10;
  localparam logic [WIN_W-1:0] OFF_DATE    = 5'h12;
  localparam logic [WIN_W-1:0] OFF_REV     = 5'h14;
  localparam logic [WIN_W-1:0] OFF_SIG     = 5'h16;
  localparam logic [WIN_W-1:0] OFF_EXC     = 5'h18;

  // Even (low-byte) offset of each host-written command word.
  function automatic logic [WIN_W-1:0] wreg_base(input int idx);
    case (idx)
      0:       return 5'h00;  // position
      1:       return 5'h06;  // frequency
      2:       return 5'h08;  // excitation amplitude
      default: return 5'h0A;  // ratio
    endcase
  endfunction

  function automatic logic is_mapped(input logic [WIN_W-1:0] off);
    case (off)
      5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h06, 5'h07, 5'h08, 5'h09,
      5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h10, 5'h11, 5'h12, 5'h13, 5'h14,
      5'h15, 5'h16, 5'h18: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/isa_rif_decode.sv
module isa_rif_decode
  import isa_rif_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [ADDR_W-WIN_W-1:0] base_sw,
  input  logic                    io_rd,
  input  logic                    io_wr,
  output logic                    hit,
  output logic [WIN_W-1:0]        off,
  output logic                    rd_hit,
  output logic                    wr_hit,
  output logic                    mapped
);
  assign hit    = (addr[ADDR_W-1:WIN_W] == base_sw);
  assign off    = addr[WIN_W-1:0];
  assign rd_hit = io_rd & hit;
  assign wr_hit = io_wr & hit;
  assign mapped = is_mapped(off);
endmodule

// File: rtl/isa_rif_wreg.sv
module isa_rif_wreg
  import isa_rif_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [WORD_W-1:0] word_q
);
  logic [BYTE_W-1:0] lo_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_stage <= RST_VAL[BYTE_W-1:0];
      word_q   <= RST_VAL;
    end else begin
      if (wr_lo) lo_stage <= wdata;
      if (wr_hi) word_q   <= {wdata, lo_stage};
    end
  end

  AST_LO_ONLY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_hi |=> $stable(word_q)); // R4

  AST_HI_COMMIT: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> word_q[WORD_W-1:BYTE_W] == $past(wdata)); // R3
endmodule

// File: rtl/isa_rif_wrap.sv
module isa_rif_wrap
  import isa_rif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_hi,
  input  logic              rd_lo,
  input  logic [BYTE_W-1:0] live_lo,
  output logic [BYTE_W-1:0] lo_byte,
  output logic              held
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      held   <= 1'b0;
    end else if (rd_hi) begin
      hold_q <= live_lo;
      held   <= 1'b1;
    end else if (rd_lo) begin
      held   <= 1'b0;
    end
  end

  assign lo_byte = held ? hold_q : live_lo;

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rd_hi |=> held && (hold_q == $past(live_lo))); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    rd_lo && !rd_hi |=> !held); // R6
endmodule

// File: rtl/isa_rif.sv
module isa_rif
  import isa_rif_pkg::*;
#(
  parameter int                ADDR_W    = 10,
  parameter logic [WORD_W-1:0] FREQ_RST  = 16'd360,
  parameter logic [WORD_W-1:0] MODEL_ID  = 16'h73D1,
  parameter logic [WORD_W-1:0] SERIAL_ID = 16'h0421,
  parameter logic [WORD_W-1:0] DATE_ID   = 16'h2419,
  parameter logic [WORD_W-1:0] REV_ID    = 16'h0004
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-WIN_W-1:0] base_sw,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    io_rd,
  input  logic                    io_wr,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [BYTE_W-1:0]       rdata,
  output logic [WORD_W-1:0]       pos_o,
  output logic [WORD_W-1:0]       freq_o,
  output logic [WORD_W-1:0]       exc_o,
  output logic [WORD_W-1:0]       ratio_o,
  input  logic [WORD_W-1:0]       wrap_i,
  input  logic [BYTE_W-1:0]       acc_stat_i,
  input  logic [BYTE_W-1:0]       sig_stat_i,
  input  logic [BYTE_W-1:0]       exc_stat_i
);
  logic             hit, rd_hit, wr_hit, mapped;
  logic [WIN_W-1:0] off;

  isa_rif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .base_sw(base_sw), .io_rd(io_rd), .io_wr(io_wr),
    .hit(hit), .off(off), .rd_hit(rd_hit), .wr_hit(wr_hit), .mapped(mapped)
  );

  // Command words, one staged register per entry.
  logic [WORD_W-1:0] words [NWREG];
  logic [NWREG-1:0]  wr_lo, wr_hi;

  for (genvar g = 0; g < NWREG; g++) begin : g_wreg
    localparam logic [WIN_W-1:0] LO_OFF = wreg_base(g);
    localparam logic [WIN_W-1:0] HI_OFF = LO_OFF | WIN_W'(1);
    assign wr_lo[g] = wr_hit && (off == LO_OFF);
    assign wr_hi[g] = wr_hit && (off == HI_OFF);
    isa_rif_wreg #(.RST_VAL((g == 1) ? FREQ_RST : '0)) u_reg (
      .clk(clk), .rst(rst), .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]),
      .wdata(wdata), .word_q(words[g])
    );
  end

  assign pos_o   = words[0];
  assign freq_o  = words[1];
  assign exc_o   = words[2];
  assign ratio_o = words[3];

  // Coherent wrap-around read.
  logic              wrap_rd_hi, wrap_rd_lo, wrap_held;
  logic [BYTE_W-1:0] wrap_lo_byte;

  assign wrap_rd_hi = rd_hit && (off == OFF_WRAP_HI);
  assign wrap_rd_lo = rd_hit && (off == OFF_WRAP_LO);

  isa_rif_wrap u_wrap (
    .clk(clk), .rst(rst), .rd_hi(wrap_rd_hi), .rd_lo(wrap_rd_lo),
    .live_lo(wrap_i[BYTE_W-1:0]), .lo_byte(wrap_lo_byte), .held(wrap_held)
  );

  // Read multiplexer.
  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (off)
      5'h00: rd_mux = words[0][BYTE_W-1:0];
      5'h01: rd_mux = words[0][WORD_W-1:BYTE_W];
      OFF_WRAP_LO: rd_mux = wrap_lo_byte;
      OFF_WRAP_HI: rd_mux = wrap_i[WORD_W-1:BYTE_W];
      OFF_ACC: rd_mux = acc_stat_i;
      5'h06: rd_mux = words[1][BYTE_W-1:0];
      5'h07: rd_mux = words[1][WORD_W-1:BYTE_W];
      5'h08: rd_mux = words[2][BYTE_W-1:0];
      5'h09: rd_mux = words[2][WORD_W-1:BYTE_W];
      5'h0A: rd_mux = words[3][BYTE_W-1:0];
      5'h0B: rd_mux = words[3][WORD_W-1:BYTE_W];
      OFF_MODEL:      rd_mux = MODEL_ID[BYTE_W-1:0];
      OFF_MODEL + 1:  rd_mux = MODEL_ID[WORD_W-1:BYTE_W];
      OFF_SERIAL:     rd_mux = SERIAL_ID[BYTE_W-1:0];
      OFF_SERIAL + 1: rd_mux = SERIAL_ID[WORD_W-1:BYTE_W];
      OFF_DATE:       rd_mux = DATE_ID[BYTE_W-1:0];
      OFF_DATE + 1:   rd_mux = DATE_ID[WORD_W-1:BYTE_W];
      OFF_REV:        rd_mux = REV_ID[BYTE_W-1:0];
      OFF_REV + 1:    rd_mux = REV_ID[WORD_W-1:BYTE_W];
      OFF_SIG: rd_mux = sig_stat_i;
      OFF_EXC: rd_mux = exc_stat_i;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= rd_mux;
  end

  AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
    io_rd && !hit |=> $stable(rdata)); // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_hit && !mapped |=> rdata == '0); // R10

  AST_LIVE_LOW: assert property (@(posedge clk) disable iff (rst)
    rd_hit && (off == OFF_WRAP_LO) && !wrap_held
      |=> rdata == $past(wrap_i[BYTE_W-1:0])); // R7

  AST_STATUS_ACC: assert property (@(posedge clk) disable iff (rst)
    rd_hit && (off == OFF_ACC) |=> rdata == $past(acc_stat_i)); // R8
endmodule

// File: tb/isa_rif_test.sv
`timescale 1ns/1ps
module isa_rif_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  base_sw = 5'b10011;
  logic [9:0]  addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] pos_o, freq_o, exc_o, ratio_o;
  logic [15:0] wrap_i = '0;
  logic [7:0]  acc_stat_i = 8'h01, sig_stat_i = 8'h03, exc_stat_i = 8'h01;

  int checks = 0, errors = 0;
  bit done = 0;
  localparam logic [9:0] BASE = 10'h260;

  isa_rif uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    chk("R2 pos", pos_o, 16'h0000);
    chk("R2 exc", exc_o, 16'h0000);
    chk("R2 ratio", ratio_o, 16'h0000);
    chk("R2 freq", freq_o, 16'd360);
    chk("R2 rdata", {8'h0, rdata}, 16'h0000);
  endtask

  task automatic t_commit;
    logic [7:0] d;
    wr(BASE + 10'h00, 8'h00); chk("R4 pos lo only", pos_o, 16'h0000);
    wr(BASE + 10'h01, 8'h80); chk("R3 pos 0x8000", pos_o, 16'h8000);
    wr(BASE + 10'h06, 8'h90); wr(BASE + 10'h07, 8'h01);
    chk("R3 freq 400", freq_o, 16'd400);
    wr(BASE + 10'h08, 8'h19); wr(BASE + 10'h09, 8'h01);
    chk("R3 exc 281", exc_o, 16'd281);
    wr(BASE + 10'h0A, 8'hFF); wr(BASE + 10'h0B, 8'hFF);
    chk("R3 ratio", ratio_o, 16'hFFFF);
    wr(BASE + 10'h0A, 8'h55); chk("R4 ratio lo only", ratio_o, 16'hFFFF);
    rd(BASE + 10'h0A, d); chk("R5 ratio lo readback", {8'h0, d}, 16'h00FF);
    wr(BASE + 10'h0B, 8'h12); chk("R3 ratio recommit", ratio_o, 16'h1255);
    rd(BASE + 10'h07, d); chk("R5 freq hi", {8'h0, d}, 16'h0001);
    rd(BASE + 10'h08, d); chk("R5 exc lo", {8'h0, d}, 16'h0019);
    rd(BASE + 10'h01, d); chk("R5 pos hi", {8'h0, d}, 16'h0080);
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    wrap_i = 16'h1234;
    rd(BASE + 10'h03, d); chk("R6 wrap hi", {8'h0, d}, 16'h0012);
    wrap_i = 16'hABCD;
    rd(BASE + 10'h02, d); chk("R6 wrap held lo", {8'h0, d}, 16'h0034);
    rd(BASE + 10'h02, d); chk("R7 wrap live lo", {8'h0, d}, 16'h00CD);
    // change source in the same cycle as the high-byte strobe
    @(negedge clk); addr = BASE + 10'h03; io_rd = 1'b1; wrap_i = 16'h5A6B;
    @(negedge clk); io_rd = 1'b0; d = rdata; wrap_i = 16'h0F0F;
    chk("R6 collide hi", {8'h0, d}, 16'h005A);
    rd(BASE + 10'h02, d); chk("R6 collide lo", {8'h0, d}, 16'h006B);
  endtask

  task automatic t_status_id;
    logic [7:0] d;
    rd(BASE + 10'h04, d); chk("R8 acc", {8'h0, d}, 16'h0001);
    rd(BASE + 10'h16, d); chk("R8 sig", {8'h0, d}, 16'h0003);
    exc_stat_i = 8'h00;
    rd(BASE + 10'h18, d); chk("R8 exc", {8'h0, d}, 16'h0000);
    rd(BASE + 10'h0D, d); chk("R9 model hi", {8'h0, d}, 16'h0073);
    rd(BASE + 10'h10, d); chk("R9 serial lo", {8'h0, d}, 16'h0021);
    rd(BASE + 10'h13, d); chk("R9 date hi", {8'h0, d}, 16'h0024);
    rd(BASE + 10'h14, d); chk("R9 rev lo", {8'h0, d}, 16'h0004);
    wr(BASE + 10'h0C, 8'hEE);
    rd(BASE + 10'h0C, d); chk("R9 model write ignored", {8'h0, d}, 16'h00D1);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    rd(BASE + 10'h05, d); chk("R10 read 05", {8'h0, d}, 16'h0000);
    wr(BASE + 10'h0E, 8'h77); wr(BASE + 10'h1F, 8'h77);
    rd(BASE + 10'h1F, d); chk("R10 read 1F", {8'h0, d}, 16'h0000);
    chk("R10 pos untouched", pos_o, 16'h8000);
    chk("R10 ratio untouched", ratio_o, 16'h1255);
  endtask

  task automatic t_window;
    logic [7:0] d;
    rd(BASE + 10'h16, d);                       // rdata now 0x03
    rd(10'h2A0 + 10'h01, d); chk("R1 outside read keeps rdata", {8'h0, d}, 16'h0003);
    wr(10'h2A0 + 10'h01, 8'h11); chk("R1 outside write", pos_o, 16'h8000);
    wrap_i = 16'h2233;
    rd(10'h2A0 + 10'h03, d);                    // no capture expected
    wrap_i = 16'h4455;
    rd(BASE + 10'h02, d); chk("R1 outside no capture", {8'h0, d}, 16'h0055);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_commit();
    t_wrap();
    t_status_id();
    t_unmapped();
    t_window();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule